// File: doc/BRIEF.md
# I2C Slave with Multi-Byte Word Transfers

This block is the target side of a two-wire I2C bus. It oversamples SCL and SDA on the system clock, recognises start and stop conditions and compares the 7-bit address of each transaction with a programmed identity. When the address matches, the block acknowledges it and takes the direction of the transfer from the bit that follows the address. It then moves data one byte per nine SCL pulses and handles the acknowledge slot of every byte.

On the local side the block deals in whole words rather than bytes. A length setting selects words of one, two or three bytes. Bytes written by the bus master are collected most significant byte first into a right-aligned word with a valid/read handshake. A word loaded by the local processor is sent to a reading master most significant byte first. Receive and transmit readiness, receive overrun and bus protocol errors each drive their own interrupt line.

Top module: `i2c_word_slave`

## Requirements
- R1: During and just after synchronous reset, sda_oe, rx_valid, busy, dir_tx, irq_rxerr and irq_buserr are 0 and tx_empty is 1.
- R2: A start condition (SDA falling while SCL is high) followed by a matching address sets busy. A stop condition (SDA rising while SCL is high) clears busy.
- R3: The 7 address bits are taken MSB first on SCL rising edges. On a match with cfg_addr the block pulls SDA low in the ninth clock. On a mismatch it leaves SDA released in the ninth clock and in all later clocks until the next start.
- R4: The eighth address bit selects the direction: 0 means the master writes and dir_tx stays 0; 1 means the block transmits and dir_tx is 1 while it is addressed.
- R5: In a write transfer, the block pulls SDA low in the acknowledge clock of every data byte. SDA changes only while SCL is low.
- R6: cfg_wlen sets the word length: 0 gives one byte, 1 gives two bytes, 2 or 3 gives three bytes. Received words are assembled MSB first and appear right-aligned on rx_data with the unused upper bits at zero.
- R7: The bytes of an incomplete word are discarded when a start or stop condition occurs.
- R8: rx_valid stays high and rx_data stays unchanged until rx_read is pulsed. A word completed while rx_valid is still high is dropped and sets irq_rxerr, which stays set until err_clr.
- R9: tx_load captures tx_data only while tx_empty is 1; a load while tx_empty is 0 is ignored. The low bytes of the loaded word, as many as the length setting selects, are sent MSB first. tx_empty returns to 1 as the first byte of the word starts.
- R10: If no word is loaded when a transmitted word begins, every byte of that word is sent as 0xFF.
- R11: An acknowledge (SDA low) from the master after a transmitted byte makes the block send the next byte. A not-acknowledge makes it release SDA and ignore the bus until the next start.
- R12: A start or stop condition after one to eight bits of a byte have been clocked sets irq_buserr, which stays set until err_clr. The block then returns to idle and ignores the bus until a following start.
- R13: irq_rx equals rx_valid and irq_tx equals tx_empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| cfg_addr | input | 7 | Own 7-bit bus address |
| cfg_wlen | input | 2 | Word length: 0 = 8, 1 = 16, 2/3 = 24 bits |
| rx_data | output | 24 | Last received word, right-aligned |
| rx_valid | output | 1 | rx_data holds an unread word |
| rx_read | input | 1 | Pulse: the processor took rx_data |
| tx_data | input | 24 | Word to transmit |
| tx_load | input | 1 | Pulse: capture tx_data |
| tx_empty | output | 1 | Transmit holding register is free |
| err_clr | input | 1 | Pulse: clear both error flags |
| busy | output | 1 | Block is addressed in a transaction |
| dir_tx | output | 1 | Addressed for a read (block transmits) |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rxerr | output | 1 | Receive overrun interrupt request |
| irq_buserr | output | 1 | Bus protocol error interrupt request |

## Verification
A wrong bit counter or bus state shows up on SDA within one SCL period: an acknowledge is missing, appears in the wrong clock, or a transmitted bit is shifted. The master observes this on the next acknowledge slot or data bit. A fault in the byte index or word accumulator cannot be seen until the word boundary. There it appears as a wrong word on rx_data or a wrong byte order on SDA, so the bench checks every length setting and a word cut short by a stop. The error flags are checked at the ports within a few system clocks of the offending condition.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } bus_st_t;
endpackage

// File: rtl/i2cw_sense.sv
module i2cw_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_s, sda_s, scl_d, sda_d;

  assign scl_s = scl_sh[SYNC_STAGES-1];
  assign sda_s = sda_sh[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
      scl_lvl  <= 1'b1;
      sda_lvl  <= 1'b1;
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
      start_p  <= 1'b0;
      stop_p   <= 1'b0;
    end else begin
      scl_sh   <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh   <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
      scl_lvl  <= scl_s;
      sda_lvl  <= sda_s;
      scl_rise <= scl_s & ~scl_d;
      scl_fall <= ~scl_s & scl_d;
      start_p  <= scl_s & scl_d & sda_d & ~sda_s;
      stop_p   <= scl_s & scl_d & ~sda_d & sda_s;
    end
  end

  assert_events_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(start_p && stop_p));
  assert_edges_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(scl_rise && scl_fall));
endmodule

// File: rtl/i2cw_link.sv
module i2cw_link
  import i2cw_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = BYTE_W - 1,
  localparam int CNT_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_stb,
  output logic              tx_take,
  output logic              xfer_begin,
  output logic              xfer_end,
  output logic              bus_err_p,
  output logic              addressed,
  output logic              rw_q
);
  bus_st_t           st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              ack_seen;
  logic              m_ack;
  logic              in_byte;

  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  assign in_byte   = ((st == ST_ADDR) || (st == ST_RX) || (st == ST_TX)) && (cnt != '0);
  assign rx_byte   = sh;
  assign addressed = (st != ST_IDLE) && (st != ST_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      sh         <= '0;
      ack_seen   <= 1'b0;
      m_ack      <= 1'b0;
      rw_q       <= 1'b0;
      sda_oe     <= 1'b0;
      rx_stb     <= 1'b0;
      tx_take    <= 1'b0;
      xfer_begin <= 1'b0;
      xfer_end   <= 1'b0;
      bus_err_p  <= 1'b0;
    end else begin
      rx_stb     <= 1'b0;
      tx_take    <= 1'b0;
      xfer_begin <= 1'b0;
      xfer_end   <= 1'b0;
      bus_err_p  <= 1'b0;
      if (start_p || stop_p) begin
        xfer_end <= 1'b1;
        sda_oe   <= 1'b0;
        cnt      <= '0;
        if (in_byte) begin
          bus_err_p <= 1'b1;
          st        <= ST_IDLE;
        end else begin
          st <= start_p ? ST_ADDR : ST_IDLE;
        end
      end else begin
        unique case (st)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise && cnt != FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_lvl};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (sh[BYTE_W-1:1] == cfg_addr) begin
                sda_oe     <= 1'b1;
                rw_q       <= sh[0];
                ack_seen   <= 1'b0;
                xfer_begin <= 1'b1;
                st         <= ST_ADDR_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_rise) begin
              ack_seen <= 1'b1;
            end else if (scl_fall && ack_seen) begin
              cnt <= '0;
              if (rw_q) begin
                sh      <= tx_byte;
                sda_oe  <= ~tx_byte[BYTE_W-1];
                tx_take <= 1'b1;
                st      <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise && cnt != FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_lvl};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              rx_stb   <= 1'b1;
              sda_oe   <= 1'b1;
              ack_seen <= 1'b0;
              st       <= ST_RX_ACK;
            end
          end
          ST_RX_ACK: begin
            if (scl_rise) begin
              ack_seen <= 1'b1;
            end else if (scl_fall && ack_seen) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise && cnt != FULL) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              sda_oe   <= 1'b0;
              ack_seen <= 1'b0;
              st       <= ST_TX_ACK;
            end else if (scl_fall && cnt != '0) begin
              sda_oe <= ~sh[BYTE_W-2];
              sh     <= {sh[BYTE_W-2:0], 1'b0};
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              m_ack    <= ~sda_lvl;
              ack_seen <= 1'b1;
            end else if (scl_fall && ack_seen) begin
              cnt <= '0;
              if (m_ack) begin
                sh      <= tx_byte;
                sda_oe  <= ~tx_byte[BYTE_W-1];
                tx_take <= 1'b1;
                st      <= ST_TX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_oe);
  assert_drive_scl_low_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_lvl));
  assert_cnt_bound_R12: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
endmodule

// File: rtl/i2cw_pack.sv
module i2cw_pack #(
  parameter int BYTE_W     = 8,
  parameter int NBYTES_MAX = 3,
  localparam int WORD_W = BYTE_W * NBYTES_MAX,
  localparam int IDX_W  = $clog2(NBYTES_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_wlen,
  input  logic              xfer_begin,
  input  logic              xfer_end,
  input  logic              rx_stb,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              tx_take,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_load,
  input  logic              rx_read,
  input  logic              err_clr,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_ovf,
  output logic              tx_empty
);
  logic [IDX_W-1:0]  nb, ri, ti;
  logic [WORD_W-1:0] acc, word_in;
  logic [WORD_W-1:0] hold, txw, aligned, cur;
  logic              full;

  always_comb begin
    if (int'(cfg_wlen) >= NBYTES_MAX - 1) nb = IDX_W'(NBYTES_MAX);
    else                                  nb = IDX_W'(cfg_wlen) + IDX_W'(1);
  end

  assign word_in  = {acc[WORD_W-BYTE_W-1:0], rx_byte};
  assign aligned  = hold << (BYTE_W * (NBYTES_MAX - int'(nb)));
  assign cur      = (ti == '0) ? (full ? aligned : '1) : txw;
  assign tx_byte  = cur[WORD_W-1 -: BYTE_W];
  assign tx_empty = ~full;

  // receive side: assemble bytes into words
  always_ff @(posedge clk) begin
    if (rst) begin
      ri       <= '0;
      acc      <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_ovf   <= 1'b0;
    end else begin
      if (rx_read) rx_valid <= 1'b0;
      if (err_clr) rx_ovf   <= 1'b0;
      if (xfer_begin || xfer_end) begin
        ri  <= '0;
        acc <= '0;
      end else if (rx_stb) begin
        if (ri == nb - IDX_W'(1)) begin
          ri  <= '0;
          acc <= '0;
          if (rx_valid && !rx_read) begin
            rx_ovf <= 1'b1;
          end else begin
            rx_data  <= word_in;
            rx_valid <= 1'b1;
          end
        end else begin
          acc <= word_in;
          ri  <= ri + IDX_W'(1);
        end
      end
    end
  end

  // transmit side: holding register split into bytes
  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
      full <= 1'b0;
      txw  <= '0;
      ti   <= '0;
    end else begin
      if (tx_take) begin
        txw <= cur << BYTE_W;
        if (ti == '0) full <= 1'b0;
        ti <= (ti == nb - IDX_W'(1)) ? '0 : ti + IDX_W'(1);
      end else if (xfer_begin || xfer_end) begin
        ti <= '0;
      end
      if (tx_load && !full) begin
        hold <= tx_data;
        full <= 1'b1;
      end
    end
  end

  assert_rx_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_read) |=> (rx_valid && $stable(rx_data)));
  assert_load_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_load && full && !tx_take) |=> $stable(hold));
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_ovf && !err_clr) |=> rx_ovf);
endmodule

// File: rtl/i2c_word_slave.sv
module i2c_word_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8,
  parameter int NBYTES_MAX  = 3,
  localparam int WORD_W = BYTE_W * NBYTES_MAX,
  localparam int ADDR_W = BYTE_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [1:0]        cfg_wlen,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_read,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_load,
  output logic              tx_empty,
  input  logic              err_clr,
  output logic              busy,
  output logic              dir_tx,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_rxerr,
  output logic              irq_buserr
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_p, stop_p;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  logic rx_stb, tx_take, xfer_begin, xfer_end, bus_err_p, addressed, rw_q;
  logic rx_ovf;

  i2cw_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p)
  );

  i2cw_link #(.BYTE_W(BYTE_W)) u_link (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p),
    .stop_p(stop_p), .cfg_addr(cfg_addr), .tx_byte(tx_byte),
    .sda_oe(sda_oe), .rx_byte(rx_byte), .rx_stb(rx_stb),
    .tx_take(tx_take), .xfer_begin(xfer_begin), .xfer_end(xfer_end),
    .bus_err_p(bus_err_p), .addressed(addressed), .rw_q(rw_q)
  );

  i2cw_pack #(.BYTE_W(BYTE_W), .NBYTES_MAX(NBYTES_MAX)) u_pack (
    .clk(clk), .rst(rst), .cfg_wlen(cfg_wlen), .xfer_begin(xfer_begin),
    .xfer_end(xfer_end), .rx_stb(rx_stb), .rx_byte(rx_byte),
    .tx_take(tx_take), .tx_byte(tx_byte), .tx_data(tx_data),
    .tx_load(tx_load), .rx_read(rx_read), .err_clr(err_clr),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ovf(rx_ovf),
    .tx_empty(tx_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      dir_tx     <= 1'b0;
      irq_buserr <= 1'b0;
    end else begin
      busy   <= addressed;
      dir_tx <= addressed & rw_q;
      if (bus_err_p)    irq_buserr <= 1'b1;
      else if (err_clr) irq_buserr <= 1'b0;
    end
  end

  assign irq_rx    = rx_valid;
  assign irq_tx    = tx_empty;
  assign irq_rxerr = rx_ovf;

  assert_buserr_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    (irq_buserr && !err_clr) |=> irq_buserr);
  assert_dir_needs_busy_R4: assert property (@(posedge clk) disable iff (rst)
    dir_tx |-> busy);
endmodule

// File: tb/sim_i2c_word_slave.sv
module sim_i2c_word_slave;
  localparam int Q = 8;
  localparam int WATCHDOG = 150000;
  localparam logic [6:0] MY_ADDR = 7'h3A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_line;
  logic sda_oe;
  logic [6:0]  cfg_addr = MY_ADDR;
  logic [1:0]  cfg_wlen = 2'd2;
  logic [23:0] rx_data, tx_data = '0;
  logic rx_valid, rx_read = 1'b0, tx_load = 1'b0, tx_empty, err_clr = 1'b0;
  logic busy, dir_tx, irq_rx, irq_tx, irq_rxerr, irq_buserr;
  int vectors = 0, fails = 0, cyc = 0;
  bit auto_rd = 1'b1;
  bit done = 1'b0;
  logic [23:0] exp_q[$];

  always #10 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_word_slave u0 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .cfg_addr(cfg_addr), .cfg_wlen(cfg_wlen), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_read(rx_read), .tx_data(tx_data),
    .tx_load(tx_load), .tx_empty(tx_empty), .err_clr(err_clr),
    .busy(busy), .dir_tx(dir_tx), .irq_rx(irq_rx), .irq_tx(irq_tx),
    .irq_rxerr(irq_rxerr), .irq_buserr(irq_buserr)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // scoreboard monitor: pop expected word when the design presents one
  always @(negedge clk) begin
    if (rx_read) rx_read <= 1'b0;
    else if (!rst && rx_valid && auto_rd) begin
      vectors++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R6 got %h expected <no word>", rx_data);
      end else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        if (rx_data !== e) begin
          fails++;
          $display("FAIL R6 got %h expected %h", rx_data, e);
        end
      end
      rx_read <= 1'b1;
    end
  end

  task automatic qwait(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start();
    m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait(); m_sda = 1'b0; qwait(); m_scl = 1'b0; qwait();
  endtask
  task automatic bus_stop();
    m_sda = 1'b0; qwait(); m_scl = 1'b1; qwait(); m_sda = 1'b1; qwait();
  endtask
  task automatic put_bit(input logic b);
    m_sda = b; qwait(); m_scl = 1'b1; qwait(); m_scl = 1'b0; qwait();
  endtask
  task automatic get_bit(output logic b);
    m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait(); b = sda_line; m_scl = 1'b0; qwait();
  endtask
  task automatic wr_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ack);
  endtask
  task automatic rd_byte(input bit give_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(give_ack ? 1'b0 : 1'b1);
  endtask
  task automatic pulse(ref logic s); @(negedge clk); s = 1'b1; @(negedge clk); s = 1'b0; endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 sda_oe", sda_oe, 0);   chk("R1 rx_valid", rx_valid, 0);
    chk("R1 tx_empty", tx_empty, 1); chk("R1 busy", busy, 0);
    chk("R1 irq_err", {irq_rxerr, irq_buserr}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 after release", {sda_oe, rx_valid, busy, dir_tx, irq_rxerr, irq_buserr}, 0);

    // R2 R3 R4 R5 R6: two 24-bit words in one write
    cfg_wlen = 2'd2;
    exp_q.push_back(24'h123456); exp_q.push_back(24'hABCDEF);
    bus_start();
    wr_byte({MY_ADDR, 1'b0}, a); chk("R3 addr ack", a, 0);
    chk("R2 busy", busy, 1); chk("R4 dir write", dir_tx, 0);
    foreach (exp_q[k]) begin
      for (int j = 2; j >= 0; j--) begin
        wr_byte(exp_q[k][j*8 +: 8], a); chk("R5 data ack", a, 0);
      end
    end
    bus_stop(); qwait();
    chk("R2 busy after stop", busy, 0);

    // R3 mismatch: no ack, bytes ignored
    bus_start();
    wr_byte({7'h3B, 1'b0}, a); chk("R3 mismatch nack", a, 1);
    wr_byte(8'h77, a);          chk("R3 ignored data", a, 1);
    bus_stop(); qwait();
    chk("R3 no word", rx_valid, 0); chk("R3 not busy", busy, 0);

    // R6 16-bit and 8-bit words
    cfg_wlen = 2'd1; exp_q.push_back(24'h00BEEF);
    bus_start(); wr_byte({MY_ADDR, 1'b0}, a);
    wr_byte(8'hBE, a); wr_byte(8'hEF, a); bus_stop(); qwait();
    cfg_wlen = 2'd0; exp_q.push_back(24'h00005A);
    bus_start(); wr_byte({MY_ADDR, 1'b0}, a);
    wr_byte(8'h5A, a); chk("R6 8-bit ack", a, 0); bus_stop(); qwait();

    // R7 partial word discarded at stop
    cfg_wlen = 2'd3;
    bus_start(); wr_byte({MY_ADDR, 1'b0}, a);
    wr_byte(8'h11, a); wr_byte(8'h22, a); bus_stop(); qwait();
    chk("R7 no partial word", rx_valid, 0);
    exp_q.push_back(24'h334455);
    bus_start(); wr_byte({MY_ADDR, 1'b0}, a);
    wr_byte(8'h33, a); wr_byte(8'h44, a); wr_byte(8'h55, a); bus_stop(); qwait();

    // R8 R13 overrun
    cfg_wlen = 2'd0; auto_rd = 1'b0;
    bus_start(); wr_byte({MY_ADDR, 1'b0}, a);
    wr_byte(8'h01, a); wr_byte(8'h02, a); chk("R8 ack on overrun", a, 0);
    bus_stop(); qwait();
    chk("R8 held word", rx_data, 24'h000001);
    chk("R8 overrun flag", irq_rxerr, 1);
    chk("R13 irq_rx", irq_rx, 1);
    exp_q.push_back(24'h000001); auto_rd = 1'b1; qwait();
    chk("R8 read clears", rx_valid, 0);
    chk("R8 flag sticky", irq_rxerr, 1);
    pulse(err_clr); @(negedge clk);
    chk("R8 flag cleared", irq_rxerr, 0);

    // R9 R4 R11 R13 transmit 24-bit, second load ignored
    cfg_wlen = 2'd2;
    chk("R13 irq_tx", irq_tx, 1);
    tx_data = 24'hA1B2C3; pulse(tx_load); @(negedge clk);
    chk("R9 tx_empty low", tx_empty, 0);
    tx_data = 24'h999999; pulse(tx_load);
    bus_start(); wr_byte({MY_ADDR, 1'b1}, a); chk("R4 read addr ack", a, 0);
    chk("R4 dir read", dir_tx, 1);
    rd_byte(1, b); chk("R9 byte0", b, 8'hA1);
    rd_byte(1, b); chk("R11 byte1", b, 8'hB2);
    rd_byte(0, b); chk("R9 byte2", b, 8'hC3);
    bus_stop(); qwait();
    chk("R9 empty after", tx_empty, 1);

    // R10 nothing loaded
    bus_start(); wr_byte({MY_ADDR, 1'b1}, a);
    rd_byte(1, b); chk("R10 fill0", b, 8'hFF);
    rd_byte(1, b); rd_byte(0, b); chk("R10 fill2", b, 8'hFF);
    bus_stop(); qwait();

    // R11 NACK releases SDA
    cfg_wlen = 2'd1; tx_data = 24'h00C0DE; pulse(tx_load);
    bus_start(); wr_byte({MY_ADDR, 1'b1}, a);
    rd_byte(1, b); chk("R11 16-bit hi", b, 8'hC0);
    rd_byte(0, b); chk("R11 16-bit lo", b, 8'hDE);
    get_bit(a); chk("R11 released after nack", a, 1);
    chk("R11 sda_oe", sda_oe, 0);
    bus_stop(); qwait();

    // R12 stop inside address byte
    bus_start(); for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop(); qwait();
    chk("R12 buserr on stop", irq_buserr, 1); chk("R12 idle", busy, 0);
    pulse(err_clr); @(negedge clk);
    chk("R12 cleared", irq_buserr, 0);
    // R12 start inside data byte, next address ignored
    cfg_wlen = 2'd0;
    bus_start(); wr_byte({MY_ADDR, 1'b0}, a);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_start(); qwait();
    chk("R12 buserr on start", irq_buserr, 1);
    wr_byte({MY_ADDR, 1'b0}, a); chk("R12 ignored until start", a, 1);
    bus_stop(); qwait();
    pulse(err_clr);

    repeat (40) @(negedge clk);
    chk("R6 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule